// File: doc/BRIEF.md
# Sponge Permutation Single Round

This block computes one round of a 320-bit sponge permutation as pure combinational logic. The state is five 64-bit words. The round runs three layers in a fixed order. First a round-dependent byte is XORed into the state. Then a 5-bit substitution box is applied to each of the 64 bit columns. Last, each word is XORed with two right-rotated copies of itself, and the two rotation amounts differ from word to word.

The block has no clock and no storage. An outer controller holds the state in its own register, feeds it back through this round once per cycle, and chooses the round index. That controller also decides how many rounds to run and which mode is in use. The output follows the inputs within the same cycle, so the controller registers `state_o` at the next edge.

Top module: `sponge_round`

## Requirements
- R1: Word x0 occupies `state_i[319:256]`, x1 `[255:192]`, x2 `[191:128]`, x3 `[127:64]` and x4 `[63:0]`; `state_o` uses the same packing.
- R2: The constant layer XORs the byte `{(15 - round_i) mod 16, round_i}` (high nibble, low nibble) into bits [7:0] of x2 and leaves every other state bit unchanged. This holds for all 16 values of `round_i`.
- R3: The substitution layer maps each column j (bit j of x0..x4, with x0 as the most significant bit of the 5-bit value) through the table 04 0b 1f 14 1a 15 09 02 1b 05 08 12 1d 03 06 1c 1e 13 07 0e 00 0d 11 18 10 0c 01 19 16 0a 0f 17 (hex, indexed 0 to 31). Output bit 4 of the table goes back to x0 and bit 0 to x4.
- R4: All 64 columns are substituted independently. Changing one input bit alters the substitution output only in that bit's column.
- R5: The diffusion layer replaces each word w with w ^ rotr(w,a) ^ rotr(w,b), where (a,b) is (19,28) for x0, (61,39) for x1, (1,6) for x2, (10,17) for x3 and (7,41) for x4.
- R6: `state_o` equals diffusion(substitution(constant(`state_i`, `round_i`))), applied in exactly that order.
- R7: The block is combinational. `state_o` reflects the current `state_i` and `round_i` in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| state_i | input | 320 | Current permutation state, x0 in the top word |
| round_i | input | 4 | Absolute round index selecting the constant |
| state_o | output | 320 | State after one full round |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between `state_i`/`round_i` and `state_o`. The bench drives a new state and round index just after a rising edge. It compares the output with its own reference round at the following falling edge, half a cycle later. Because the stimulus is never changed at that falling edge, each comparison sees settled logic for exactly one stimulus.

// File: rtl/sponge_pkg.sv
package sponge_pkg;
  localparam int unsigned WORD_W    = 64;
  localparam int unsigned NUM_WORDS = 5;
  localparam int unsigned RIDX_W    = 4;
  localparam int unsigned STATE_W   = WORD_W * NUM_WORDS;
  localparam int unsigned COL_W     = NUM_WORDS;
  localparam int unsigned X2_IDX    = 2;
  localparam int unsigned CONST_W   = 2 * RIDX_W;

  // rotation pairs per word, x0 first
  localparam int unsigned ROT_A [NUM_WORDS] = '{19, 61, 1, 10, 7};
  localparam int unsigned ROT_B [NUM_WORDS] = '{28, 39, 6, 17, 41};

  // lsb offset of word k in the packed state (x0 highest)
  function automatic int unsigned word_lsb(int unsigned k);
    return (NUM_WORDS - 1 - k) * WORD_W;
  endfunction

  function automatic logic [COL_W-1:0] sbox5(logic [COL_W-1:0] v);
    logic [COL_W-1:0] r;
    case (v)
      5'd0:  r = 5'h04;  5'd1:  r = 5'h0b;  5'd2:  r = 5'h1f;  5'd3:  r = 5'h14;
      5'd4:  r = 5'h1a;  5'd5:  r = 5'h15;  5'd6:  r = 5'h09;  5'd7:  r = 5'h02;
      5'd8:  r = 5'h1b;  5'd9:  r = 5'h05;  5'd10: r = 5'h08;  5'd11: r = 5'h12;
      5'd12: r = 5'h1d;  5'd13: r = 5'h03;  5'd14: r = 5'h06;  5'd15: r = 5'h1c;
      5'd16: r = 5'h1e;  5'd17: r = 5'h13;  5'd18: r = 5'h07;  5'd19: r = 5'h0e;
      5'd20: r = 5'h00;  5'd21: r = 5'h0d;  5'd22: r = 5'h11;  5'd23: r = 5'h18;
      5'd24: r = 5'h10;  5'd25: r = 5'h0c;  5'd26: r = 5'h01;  5'd27: r = 5'h19;
      5'd28: r = 5'h16;  5'd29: r = 5'h0a;  5'd30: r = 5'h0f;  default: r = 5'h17;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/round_const_add.sv
module round_const_add
  import sponge_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  input  logic [RIDX_W-1:0]  round_i,
  output logic [STATE_W-1:0] state_o
);
  localparam int unsigned CLSB = (NUM_WORDS - 1 - X2_IDX) * WORD_W;

  logic [RIDX_W-1:0]  hi_nib;
  logic [CONST_W-1:0] rc;
  logic [STATE_W-1:0] rc_wide;
  logic [STATE_W-1:0] delta;
  logic [STATE_W-1:0] outside_mask;

  always_comb begin
    hi_nib  = {RIDX_W{1'b1}} - round_i;
    rc      = {hi_nib, round_i};
    rc_wide = '0;
    rc_wide[CLSB +: CONST_W] = rc;
    state_o = state_i ^ rc_wide;
  end

  always_comb begin
    outside_mask = '1;
    outside_mask[CLSB +: CONST_W] = '0;
    delta = state_o ^ state_i;
  end

  always_comb begin
    assert_const_confined_R2: assert ((delta & outside_mask) == '0)
      else $error("constant touched bits outside x2 low byte");
    assert_const_nibbles_R2: assert ((delta[CLSB +: RIDX_W] + delta[CLSB+RIDX_W +: RIDX_W])
                                     == {RIDX_W{1'b1}})
      else $error("constant nibbles do not sum to all ones");
  end
endmodule

// File: rtl/sbox_layer.sv
module sbox_layer
  import sponge_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  output logic [STATE_W-1:0] state_o
);
  for (genvar j = 0; j < WORD_W; j++) begin : g_col
    logic [COL_W-1:0] col_in;
    logic [COL_W-1:0] col_out;
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_gather
      // x0 lands on the msb of the column value
      assign col_in[COL_W-1-k] = state_i[(NUM_WORDS-1-k)*WORD_W + j];
      assign state_o[(NUM_WORDS-1-k)*WORD_W + j] = col_out[COL_W-1-k];
    end
    assign col_out = sbox5(col_in);
  end

  localparam logic [COL_W-1:0] ZERO_IMG = 5'h04;
  localparam logic [COL_W-1:0] ONES_IMG = 5'h17;

  function automatic logic [STATE_W-1:0] spread(logic [COL_W-1:0] c);
    logic [STATE_W-1:0] s;
    for (int k = 0; k < NUM_WORDS; k++)
      s[(NUM_WORDS-1-k)*WORD_W +: WORD_W] = {WORD_W{c[COL_W-1-k]}};
    return s;
  endfunction

  always_comb begin
    if (state_i == '0)
      assert_zero_cols_R3: assert (state_o == spread(ZERO_IMG))
        else $error("all-zero state substituted wrongly");
    if (state_i == '1)
      assert_ones_cols_R3: assert (state_o == spread(ONES_IMG))
        else $error("all-ones state substituted wrongly");
  end
endmodule

// File: rtl/diffusion_layer.sv
module diff_word
  import sponge_pkg::*;
#(
  parameter int unsigned ROT_1 = 1,
  parameter int unsigned ROT_2 = 2
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] r1, r2;
  assign r1     = (word_i >> ROT_1) | (word_i << (WORD_W - ROT_1));
  assign r2     = (word_i >> ROT_2) | (word_i << (WORD_W - ROT_2));
  assign word_o = word_i ^ r1 ^ r2;

  // three copies of one word keep its parity
  always_comb begin
    assert_parity_kept_R5: assert ((^word_o) == (^word_i))
      else $error("diffusion changed word parity");
  end
endmodule

module diffusion_layer
  import sponge_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  output logic [STATE_W-1:0] state_o
);
  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    diff_word #(
      .ROT_1(ROT_A[k]),
      .ROT_2(ROT_B[k])
    ) i_diff_word (
      .word_i(state_i[(NUM_WORDS-1-k)*WORD_W +: WORD_W]),
      .word_o(state_o[(NUM_WORDS-1-k)*WORD_W +: WORD_W])
    );
  end
endmodule

// File: rtl/sponge_round.sv
module sponge_round
  import sponge_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  input  logic [RIDX_W-1:0]  round_i,
  output logic [STATE_W-1:0] state_o
);
  logic [STATE_W-1:0] after_const;
  logic [STATE_W-1:0] after_sbox;

  round_const_add i_round_const_add (
    .state_i(state_i),
    .round_i(round_i),
    .state_o(after_const)
  );

  sbox_layer i_sbox_layer (
    .state_i(after_const),
    .state_o(after_sbox)
  );

  diffusion_layer i_diffusion_layer (
    .state_i(after_sbox),
    .state_o(state_o)
  );
endmodule

// File: tb/test_sponge_round.sv
`timescale 1ns/1ps
module test_sponge_round;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [319:0] state_i = '0;
  logic [3:0]   round_i = '0;
  logic [319:0] state_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sponge_round i_sponge_round (
    .state_i(state_i),
    .round_i(round_i),
    .state_o(state_o)
  );

  function automatic logic [63:0] rotr(logic [63:0] w, int n);
    logic [127:0] d;
    d = {w, w} >> n;
    return d[63:0];
  endfunction

  // reference round: bitsliced boolean form of the substitution
  function automatic logic [319:0] ref_round(logic [319:0] s, logic [3:0] r);
    logic [63:0] x0, x1, x2, x3, x4, t0, t1, t2, t3, t4;
    logic [3:0] hn;
    x0 = s[319:256]; x1 = s[255:192]; x2 = s[191:128]; x3 = s[127:64]; x4 = s[63:0];
    hn = 4'd15 - r;
    x2[7:0] = x2[7:0] ^ {hn, r};
    x0 = x0 ^ x4; x4 = x4 ^ x3; x2 = x2 ^ x1;
    t0 = ~x0 & x1; t1 = ~x1 & x2; t2 = ~x2 & x3; t3 = ~x3 & x4; t4 = ~x4 & x0;
    x0 = x0 ^ t1; x1 = x1 ^ t2; x2 = x2 ^ t3; x3 = x3 ^ t4; x4 = x4 ^ t0;
    x1 = x1 ^ x0; x0 = x0 ^ x4; x3 = x3 ^ x2; x2 = ~x2;
    x0 = x0 ^ rotr(x0, 19) ^ rotr(x0, 28);
    x1 = x1 ^ rotr(x1, 61) ^ rotr(x1, 39);
    x2 = x2 ^ rotr(x2, 1)  ^ rotr(x2, 6);
    x3 = x3 ^ rotr(x3, 10) ^ rotr(x3, 17);
    x4 = x4 ^ rotr(x4, 7)  ^ rotr(x4, 41);
    return {x0, x1, x2, x3, x4};
  endfunction

  task automatic apply(input logic [319:0] s, input logic [3:0] r, input string tag);
    logic [319:0] exp;
    @(posedge clk);
    #1;
    state_i = s;
    round_i = r;
    exp = ref_round(s, r);
    @(negedge clk);
    checks++;
    if (state_o !== exp) begin
      failures++;
      $display("FAIL %s round=%0d actual=%h expected=%h", tag, r, state_o, exp);
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(10 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [319:0] s;
    // R1 R7: zero state held during reset, result in the same cycle
    apply('0, 4'd0, "R7 zero state during reset");
    rst_ni = 1'b1;
    // R2: every round index on zero and on all-ones states
    for (int r = 0; r < 16; r++) apply('0, 4'(r), "R2 constant on zero state");
    for (int r = 0; r < 16; r++) apply('1, 4'(r), "R2 constant on ones state");
    // R3: every column value at every column position
    for (int k = 0; k < 32; k++) begin
      s = '0;
      for (int j = 0; j < 64; j++) begin
        logic [4:0] v;
        v = 5'((j + k) % 32);
        for (int w = 0; w < 5; w++) s[(4 - w) * 64 + j] = v[4 - w];
      end
      apply(s, 4'(k % 12), "R3 column table sweep");
    end
    // R1 R4: single-bit states, one per word and scattered positions
    for (int b = 0; b < 320; b += 7) begin
      s = '0;
      s[b] = 1'b1;
      apply(s, 4'd5, "R4 single bit column isolation");
    end
    for (int w = 0; w < 5; w++) begin
      s = '0;
      s[(4 - w) * 64 +: 64] = 64'h8000_0000_0000_0001;
      apply(s, 4'd0, "R1 word packing and R5 rotation");
    end
    // R5 R6: random states across rounds
    for (int n = 0; n < 200; n++) begin
      for (int q = 0; q < 10; q++) s[q * 32 +: 32] = $urandom;
      apply(s, 4'(n % 16), "R6 full round on random state");
    end
    // R7: back-to-back changes each cycle
    for (int n = 0; n < 12; n++) begin
      s = {10{32'(n * 32'h9e37_79b9)}};
      apply(s, 4'(n), "R7 same-cycle update");
    end
    done = 1'b1;
    finish_run();
  end
endmodule